// File: doc/BRIEF.md
# Shadow-Backed SRAM Store/Recall Engine

This block is a clocked model of a byte-wide working RAM paired with a nonvolatile shadow array of the same size. Outside of copy operations it acts as a plain RAM. A chip-enable, a write-enable and an output-enable strobe, all active high, select a read or a write. A read returns its byte one clock later, together with a flag that tells whether the data drivers are on.

Two commands move the whole contents between the arrays. A store first erases the shadow and then programs it from the working RAM. A recall first clears the working RAM and then fills it from the shadow. Each phase handles one byte per clock in ascending address order. While a copy runs, `busy` is high, and every external read and write is ignored.

Two power-good levels add gating. When the supply level is low, a recall request is latched. The recall then runs on its own once the supply is good again. Reset also latches this request, so a recall follows every power-up. When the storage capacitor level is low, writes and store commands are blocked.

Top module: `nvsram_core`

## Requirements
- R1: With `ce`=1, `oe`=1, `we`=0, `busy`=0 and `vcc_ok`=1 at a clock edge, after that edge `dq_oe`=1 and `dout` holds the working byte at `addr`. In every other cycle `dq_oe` is 0.
- R2: With `ce`=1, `we`=1, `busy`=0, `vcc_ok`=1 and `cap_ok`=1 at a clock edge, `din` is written into the working byte at `addr`.
- R3: When `ce` and `we` are both 1 at an edge, `dq_oe` is 0 after that edge, even if `oe` is 1.
- R4: An accepted store raises `busy` at the accepting edge and keeps it high for exactly 2·2^ADDR_W cycles. At the end, the shadow equals the working RAM.
- R5: A recall also lasts 2·2^ADDR_W cycles. It leaves the working RAM equal to the shadow and does not change the shadow, so it may be repeated any number of times.
- R6: While `busy` is 1, external writes change nothing and reads leave `dq_oe` at 0.
- R7: A store or recall command that arrives while `busy` is 1 is dropped. It does not start after the running operation ends.
- R8: A recall request is latched at reset and in every cycle with `vcc_ok`=0. The first edge with `vcc_ok`=1 and `busy`=0 then starts a recall.
- R9: With `cap_ok`=0, writes and store commands are ignored, while a recall command is still accepted.
- R10: Commands accepted at the same edge follow a fixed priority: a latched power recall first, then store, then recall.
- R11: While `vcc_ok`=0, no access or command is accepted and `dq_oe` is 0.
- R12: In a store, the first 2^ADDR_W cycles write 0x00 into each shadow byte, and the second 2^ADDR_W cycles copy each working byte into the shadow. A recall does the same on the working RAM. Both walk addresses in ascending order.
- R13: Each array holds 2^ADDR_W bytes of DATA_W bits. ADDR_W=13 with DATA_W=8 gives the full 8192-byte organisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; latches a recall request |
| ce | input | 1 | Chip enable, active high |
| we | input | 1 | Write enable, active high |
| oe | input | 1 | Output enable, active high |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, registered |
| dq_oe | output | 1 | High when the read data drivers are on |
| cmd_store | input | 1 | Store command, sampled when idle |
| cmd_recall | input | 1 | Recall command, sampled when idle |
| vcc_ok | input | 1 | Supply level above its threshold |
| cap_ok | input | 1 | Storage capacitor level above its threshold |
| busy | output | 1 | A store or recall is in progress |

## Verification
The bench builds the block with ADDR_W=4, DATA_W=8 and a registered read path. A whole store or recall therefore takes 32 cycles. This lets the bench measure every copy's length exactly and read back every byte after each operation. The small depth also lets one run cover power-up recall, repeated recalls, dropped commands during a copy, blocking by the capacitor level, command priority and recall after a supply drop.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_STORE  = 2'd1,
      OP_RECALL = 2'd2
   } nvs_op_e;

   typedef enum logic {
      PH_WIPE = 1'b0,
      PH_COPY = 1'b1
   } nvs_phase_e;
endpackage

// File: rtl/nvs_array.sv
module nvs_array #(
   parameter int AW  = 11,
   parameter int DW  = 8,
   parameter int NRD = 1
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [AW-1:0]           waddr,
   input  logic [DW-1:0]           wdata,
   input  logic [NRD-1:0][AW-1:0]  raddr,
   output logic [NRD-1:0][DW-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;

   if (NRD < 1 || NRD > 4) begin : g_bad_nrd
      $error("nvs_array: NRD must be 1..4");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = mem[raddr[p]];
   end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
   import nvs_pkg::*;
#(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vcc_ok,
   input  logic          cap_ok,
   input  logic          cmd_store,
   input  logic          cmd_recall,
   input  logic [DW-1:0] wk_rdata,
   input  logic [DW-1:0] sh_rdata,
   output logic          busy,
   output nvs_op_e       op,
   output nvs_phase_e    phase,
   output logic [AW-1:0] idx,
   output logic          pend,
   output logic          sh_we,
   output logic [DW-1:0] sh_wdata,
   output logic          wk_we,
   output logic [DW-1:0] wk_wdata
);
   localparam logic [AW-1:0] LAST = {AW{1'b1}};

   logic    accept;
   logic    last;
   nvs_op_e next_op;

   assign last   = (idx == LAST);
   assign accept = !busy && vcc_ok && (pend || (cmd_store && cap_ok) || cmd_recall);

   always_comb begin
      if (pend)                   next_op = OP_RECALL;
      else if (cmd_store && cap_ok) next_op = OP_STORE;
      else                        next_op = OP_RECALL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         op    <= OP_NONE;
         phase <= PH_WIPE;
         idx   <= '0;
         pend  <= 1'b1;
      end else begin
         if (!vcc_ok)            pend <= 1'b1;
         else if (accept && pend) pend <= 1'b0;

         if (accept) begin
            busy  <= 1'b1;
            op    <= next_op;
            phase <= PH_WIPE;
            idx   <= '0;
         end else if (busy) begin
            if (last) begin
               idx <= '0;
               if (phase == PH_WIPE) begin
                  phase <= PH_COPY;
               end else begin
                  busy  <= 1'b0;
                  op    <= OP_NONE;
                  phase <= PH_WIPE;
               end
            end else begin
               idx <= idx + AW'(1);
            end
         end
      end
   end

   assign sh_we    = busy && (op == OP_STORE);
   assign sh_wdata = (phase == PH_WIPE) ? '0 : wk_rdata;
   assign wk_we    = busy && (op == OP_RECALL);
   assign wk_wdata = (phase == PH_WIPE) ? '0 : sh_rdata;
endmodule

// File: rtl/nvs_access.sv
module nvs_access #(
   parameter int DW      = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce,
   input  logic          we,
   input  logic          oe,
   input  logic          busy,
   input  logic          vcc_ok,
   input  logic          cap_ok,
   input  logic [DW-1:0] rd_byte,
   output logic [DW-1:0] dout,
   output logic          dq_oe,
   output logic          wr_en
);
   logic live;
   logic rd_en;

   assign live  = !busy && vcc_ok;
   assign rd_en = live && ce && oe && !we;
   assign wr_en = live && ce && we && cap_ok;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dq_oe <= 1'b0;
            dout  <= '0;
         end else begin
            dq_oe <= rd_en;
            if (rd_en) dout <= rd_byte;
         end
      end
   end else begin : g_comb
      assign dq_oe = rd_en;
      assign dout  = rd_en ? rd_byte : '0;
   end
endmodule

// File: rtl/nvsram_core.sv
module nvsram_core
   import nvs_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              we,
   input  logic              oe,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dq_oe,
   input  logic              cmd_store,
   input  logic              cmd_recall,
   input  logic              vcc_ok,
   input  logic              cap_ok,
   output logic              busy
);
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_aw
      $error("nvsram_core: ADDR_W must be 2..16");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_dw
      $error("nvsram_core: DATA_W must be 1..64");
   end

   nvs_op_e             op_q;
   nvs_phase_e          phase_q;
   logic [ADDR_W-1:0]   eng_idx;
   logic                pend_q;
   logic                sh_we;
   logic [DATA_W-1:0]   sh_wdata;
   logic                eng_we;
   logic [DATA_W-1:0]   eng_wdata;
   logic                ext_we;

   logic                    wk_we;
   logic [ADDR_W-1:0]       wk_waddr;
   logic [DATA_W-1:0]       wk_wdata;
   logic [1:0][ADDR_W-1:0]  wk_raddr;
   logic [1:0][DATA_W-1:0]  wk_rdata;
   logic [0:0][ADDR_W-1:0]  sh_raddr;
   logic [0:0][DATA_W-1:0]  sh_rdata;

   assign wk_we    = eng_we || ext_we;
   assign wk_waddr = eng_we ? eng_idx : addr;
   assign wk_wdata = eng_we ? eng_wdata : din;
   assign wk_raddr = {eng_idx, addr};
   assign sh_raddr = eng_idx;

   nvs_array #(.AW(ADDR_W), .DW(DATA_W), .NRD(2)) u_work (
      .clk   (clk),
      .we    (wk_we),
      .waddr (wk_waddr),
      .wdata (wk_wdata),
      .raddr (wk_raddr),
      .rdata (wk_rdata)
   );

   nvs_array #(.AW(ADDR_W), .DW(DATA_W), .NRD(1)) u_shadow (
      .clk   (clk),
      .we    (sh_we),
      .waddr (eng_idx),
      .wdata (sh_wdata),
      .raddr (sh_raddr),
      .rdata (sh_rdata)
   );

   nvs_seq #(.AW(ADDR_W), .DW(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .vcc_ok     (vcc_ok),
      .cap_ok     (cap_ok),
      .cmd_store  (cmd_store),
      .cmd_recall (cmd_recall),
      .wk_rdata   (wk_rdata[1]),
      .sh_rdata   (sh_rdata[0]),
      .busy       (busy),
      .op         (op_q),
      .phase      (phase_q),
      .idx        (eng_idx),
      .pend       (pend_q),
      .sh_we      (sh_we),
      .sh_wdata   (sh_wdata),
      .wk_we      (eng_we),
      .wk_wdata   (eng_wdata)
   );

   nvs_access #(.DW(DATA_W), .OUT_REG(OUT_REG)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce      (ce),
      .we      (we),
      .oe      (oe),
      .busy    (busy),
      .vcc_ok  (vcc_ok),
      .cap_ok  (cap_ok),
      .rd_byte (wk_rdata[0]),
      .dout    (dout),
      .dq_oe   (dq_oe),
      .wr_en   (ext_we)
   );
endmodule

// File: rtl/nvs_chk.sv
module nvs_chk
   import nvs_pkg::*;
#(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce,
   input logic              we,
   input logic              vcc_ok,
   input logic              cap_ok,
   input logic              busy,
   input logic              dq_oe,
   input logic              pend,
   input nvs_op_e           op,
   input nvs_phase_e        phase,
   input logic              sh_we,
   input logic [DATA_W-1:0] sh_wdata,
   input logic [ADDR_W-1:0] idx
);
   localparam int RUN_LEN = 2 * (1 << ADDR_W);

   logic [ADDR_W+1:0] run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 1'b1;
      else           run <= '0;
   end

   assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run == (ADDR_W+2)'(RUN_LEN));

   assert_wipe_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sh_we && phase == PH_WIPE |-> sh_wdata == '0);

   assert_idx_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> idx == '0 && phase == PH_WIPE);

   assert_store_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) && op == OP_STORE |-> $past(cap_ok));

   assert_pend_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !vcc_ok |=> pend);

   if (OUT_REG) begin : g_reg_chk
      assert_no_out_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
         busy |=> !dq_oe);
      assert_oe_off_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
         ce && we |=> !dq_oe);
      assert_no_out_lowvcc_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !vcc_ok |=> !dq_oe);
   end else begin : g_comb_chk
      assert_no_out_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
         busy |-> !dq_oe);
      assert_oe_off_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
         ce && we |-> !dq_oe);
      assert_no_out_lowvcc_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !vcc_ok |-> !dq_oe);
   end
endmodule

bind nvsram_core nvs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce       (ce),
   .we       (we),
   .vcc_ok   (vcc_ok),
   .cap_ok   (cap_ok),
   .busy     (busy),
   .dq_oe    (dq_oe),
   .pend     (pend_q),
   .op       (op_q),
   .phase    (phase_q),
   .sh_we    (sh_we),
   .sh_wdata (sh_wdata),
   .idx      (eng_idx)
);

// File: tb/sim_nvsram_core.sv
module sim_nvsram_core;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 4;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce = 1'b0, we = 1'b0, oe = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    din = '0;
   logic [7:0]    dout;
   logic          dq_oe;
   logic          cmd_store = 1'b0, cmd_recall = 1'b0;
   logic          vcc_ok = 1'b1, cap_ok = 1'b1;
   logic          busy;

   int errors = 0;
   int checks = 0;
   logic [7:0] exp_work [N];
   logic [7:0] exp_shadow [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   nvsram_core #(.ADDR_W(AW), .DATA_W(8), .OUT_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .oe(oe), .addr(addr), .din(din),
      .dout(dout), .dq_oe(dq_oe), .cmd_store(cmd_store), .cmd_recall(cmd_recall),
      .vcc_ok(vcc_ok), .cap_ok(cap_ok), .busy(busy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); ce = 1; we = 1; oe = 0; addr = a; din = d;
      @(negedge clk); ce = 0; we = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic f);
      @(negedge clk); ce = 1; oe = 1; we = 0; addr = a;
      @(negedge clk); d = dout; f = dq_oe; ce = 0; oe = 0;
   endtask

   task automatic pulse(input logic st, input logic rc);
      @(negedge clk); cmd_store = st; cmd_recall = rc;
      @(negedge clk); cmd_store = 0; cmd_recall = 0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
   endtask

   task automatic check_all(input string tag);
      logic [7:0] d; logic f; int bad = 0;
      for (int a = 0; a < N; a++) begin
         rd(AW'(a), d, f);
         if (!f || d !== exp_work[a]) bad++;
      end
      chk(bad == 0, tag, bad, 0);
   endtask

   task automatic t_reset();
      int n;
      repeat (3) @(negedge clk);
      chk(dq_oe == 0, "R1 reset dq_oe", dq_oe, 0);
      chk(busy == 0, "R8 reset busy", busy, 0);
      rst_n = 1;
      @(negedge clk);
      chk(busy == 1, "R8 power-up recall starts", busy, 1);
      wait_idle(n);
      chk(n == 2*N, "R8 power-up recall length", n, 2*N);
   endtask

   task automatic t_rw();
      for (int a = 0; a < N; a++) begin
         exp_work[a] = 8'(a*37 + 5);
         wr(AW'(a), exp_work[a]);
      end
      check_all("R1 R2 write then read all bytes");
   endtask

   task automatic t_oe_write();
      @(negedge clk); ce = 1; oe = 1; we = 0; addr = 3;
      @(negedge clk);
      chk(dq_oe == 1, "R1 read drivers on", dq_oe, 1);
      chk(dout == exp_work[3], "R1 read data", dout, exp_work[3]);
      we = 1; din = 8'h5A;
      @(negedge clk);
      chk(dq_oe == 0, "R3 drivers off on write with oe", dq_oe, 0);
      ce = 0; we = 0; oe = 0;
      exp_work[3] = 8'h5A;
      check_all("R2 write with oe stored");
   endtask

   task automatic t_store_recall();
      int n;
      pulse(1, 0);
      wait_idle(n);
      chk(n == 2*N, "R4 store length", n, 2*N);
      for (int a = 0; a < N; a++) exp_shadow[a] = exp_work[a];
      for (int a = 0; a < N; a++) begin exp_work[a] = ~exp_shadow[a]; wr(AW'(a), exp_work[a]); end
      check_all("R2 overwrite before recall");
      pulse(0, 1);
      wait_idle(n);
      chk(n == 2*N, "R5 recall length", n, 2*N);
      for (int a = 0; a < N; a++) exp_work[a] = exp_shadow[a];
      check_all("R4 R5 recall returns stored image");
      for (int a = 0; a < N; a += 3) begin exp_work[a] = 8'hC3; wr(AW'(a), 8'hC3); end
      pulse(0, 1);
      wait_idle(n);
      for (int a = 0; a < N; a++) exp_work[a] = exp_shadow[a];
      check_all("R5 second recall, shadow unchanged");
   endtask

   task automatic t_busy_ignore();
      int n; logic [7:0] d; logic f;
      pulse(1, 0);
      for (int a = 0; a < N; a++) exp_shadow[a] = exp_work[a];
      ce = 1; we = 1; addr = 0; din = ~exp_work[0];
      @(negedge clk); we = 0; oe = 1;
      @(negedge clk);
      @(negedge clk);
      chk(dq_oe == 0, "R6 no read during busy", dq_oe, 0);
      ce = 0; oe = 0; cmd_recall = 1;
      @(negedge clk); cmd_recall = 0;
      wait_idle(n);
      @(negedge clk);
      chk(busy == 0, "R7 command during busy not queued", busy, 0);
      rd(0, d, f);
      chk(d == exp_work[0], "R6 write during busy ignored", d, exp_work[0]);
   endtask

   task automatic t_cap();
      int n; logic [7:0] d; logic f;
      exp_work[2] = 8'h99; wr(2, 8'h99);
      cap_ok = 0;
      wr(1, ~exp_work[1]);
      rd(1, d, f);
      chk(d == exp_work[1], "R9 write blocked with cap low", d, exp_work[1]);
      pulse(1, 0);
      chk(busy == 0, "R9 store blocked with cap low", busy, 0);
      pulse(0, 1);
      chk(busy == 1, "R9 recall allowed with cap low", busy, 1);
      wait_idle(n);
      cap_ok = 1;
      for (int a = 0; a < N; a++) exp_work[a] = exp_shadow[a];
      rd(2, d, f);
      chk(d == exp_shadow[2], "R9 shadow kept after blocked store", d, exp_shadow[2]);
   endtask

   task automatic t_priority();
      int n; logic [7:0] d; logic f;
      wr(5, 8'h3C);
      pulse(1, 1);
      wait_idle(n);
      chk(n == 2*N, "R10 simultaneous commands run once", n, 2*N);
      wr(5, 8'hE1);
      pulse(0, 1);
      wait_idle(n);
      rd(5, d, f);
      chk(d == 8'h3C, "R10 store wins over recall", d, 8'h3C);
      exp_work[5] = 8'h3C;
      exp_shadow[5] = 8'h3C;
   endtask

   task automatic t_power();
      int n;
      wr(7, 8'h77);
      @(negedge clk); vcc_ok = 0; ce = 1; oe = 1; addr = 7;
      @(negedge clk);
      chk(dq_oe == 0, "R11 no read with supply low", dq_oe, 0);
      cmd_store = 1;
      @(negedge clk);
      chk(busy == 0, "R11 no command with supply low", busy, 0);
      cmd_store = 0; ce = 0; oe = 0; vcc_ok = 1;
      @(negedge clk);
      chk(busy == 1, "R8 recall after supply returns", busy, 1);
      wait_idle(n);
      chk(n == 2*N, "R8 supply recall length", n, 2*N);
      for (int a = 0; a < N; a++) exp_work[a] = exp_shadow[a];
      check_all("R8 R13 image restored after supply drop");
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_rw();
      t_oe_write();
      t_store_recall();
      t_busy_ignore();
      t_cap();
      t_priority();
      t_power();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule